// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a handful of register writes into the pin-level cycles of a raw 8-bit NAND flash bus. Software loads a first opcode, an optional confirm opcode, a 48-bit address and, for writes, up to four data bytes. It then writes a control word whose low bit starts the run. The control word picks the phases that run: opcode latch, address latch with a selectable byte count, second opcode latch, and a short programmed data transfer of one to four bytes in either direction.

After the last strobe the sequencer waits a fixed write-to-busy gap and then waits for the ready/busy line to report ready. Only then does it drop its run bit and post a sticky completion flag. Received bytes land little-endian in a response register. Status flags are cleared by writing ones to them. A control write that arrives while a run is in progress is dropped and flagged. Register reads return data one clock after the address is presented.

Register map (3-bit address): 0 first opcode [7:0], 1 second opcode [7:0], 2 address low [31:0], 3 address high [15:0], 4 control, 5 status, 6 response (read only), 7 transmit data [31:0]. Control bits: 0 run, 1 opcode phase, 2 address phase, 3 second opcode phase, 4 data phase, 5 direction (1 = send, 0 = receive), 6 chip enable, [9:8] address length code, [13:12] data byte count minus one. Status bits: 0 done, 1 error, 2 run (read only), 3 live ready line (read only).

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the chip enable, write strobe and read strobe are high, the bus is not driven, and the status register reads done = 0, error = 0, run = 0.
- R2: A run sends its enabled phases in the fixed order first opcode (CLE high), address bytes (ALE high), second opcode (CLE high), data. A phase whose enable bit is clear is skipped, so a reset command is a single CLE byte.
- R3: Address length code 0, 1, 2, 3 sends 1, 3, 4, 5 address bytes respectively.
- R4: Address bytes come from the 48-bit value {address high, address low}, least significant byte first, so a 5-byte address is column low, column high, page bits 7:0, page bits 15:8, page bits 23:16.
- R5: A receive phase reads (count field + 1) bytes on RE strobes and packs them little-endian into the response register; lanes not read are zero after the run.
- R6: While the ready line is low after the last strobe, the run bit stays set and done stays clear.
- R7: When the device is ready again, the run bit clears by itself and done (status bit 0) is set.
- R8: A send phase puts the transmit data register on the bus least significant byte first, with CLE and ALE low.
- R9: A control write while a run is active changes nothing, causes no extra bus cycle, and sets error (status bit 1).
- R10: Writing a 1 to a status bit clears it; writing 0 leaves it unchanged.
- R11: Every WE or RE low pulse lasts exactly T_LOW clock cycles.
- R12: Chip enable (active low) is asserted during a run only when control bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data, one cycle after rd_addr |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus byte driven to the device |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus byte from the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
A wrong phase state or byte index shows up at the next WE rising edge: the scoreboard compares CLE, ALE, CE and the bus byte there against a queue filled from the requirements. A miscounted strobe timer shows up on the same pulse as a wrong low width. A receive lane or packing fault appears in the response register as soon as the run ends. A completion or run-bit fault appears in the first status read taken while the modelled device holds the ready line low.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_DATA, S_WB, S_RB
  } seq_state_t;

  localparam logic [2:0] RA_OPC1   = 3'd0;
  localparam logic [2:0] RA_OPC2   = 3'd1;
  localparam logic [2:0] RA_ADDRLO = 3'd2;
  localparam logic [2:0] RA_ADDRHI = 3'd3;
  localparam logic [2:0] RA_CTRL   = 3'd4;
  localparam logic [2:0] RA_STAT   = 3'd5;
  localparam logic [2:0] RA_RESP   = 3'd6;
  localparam logic [2:0] RA_TXD    = 3'd7;

  localparam int CB_GO   = 0;
  localparam int CB_CLE  = 1;
  localparam int CB_ALE  = 2;
  localparam int CB_CMD2 = 3;
  localparam int CB_PIO  = 4;
  localparam int CB_TX   = 5;
  localparam int CB_CE   = 6;
endpackage

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
  parameter int T_LOW  = 2,
  parameter int T_HIGH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic low,
  output logic sample,
  output logic done
);
  localparam int TMAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(T_LOW - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(T_HIGH - 1);

  logic [1:0]    phase;   // 0 idle, 1 low, 2 high
  logic [CW-1:0] cnt;

  assign busy   = (phase != 2'd0);
  assign low    = (phase == 2'd1);
  assign sample = low && (cnt == LOW_LAST);
  assign done   = (phase == 2'd2) && (cnt == HIGH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 2'd0;
      cnt   <= '0;
    end else begin
      case (phase)
        2'd0: if (start) begin phase <= 2'd1; cnt <= '0; end
        2'd1: if (sample) begin phase <= 2'd2; cnt <= '0; end
              else cnt <= cnt + 1'b1;
        default: if (done) begin phase <= 2'd0; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        seq_finish,
  input  logic        resp_wr,
  input  logic [1:0]  resp_lane,
  input  logic [7:0]  resp_byte,
  input  logic        rb,
  output logic [7:0]  opc1,
  output logic [7:0]  opc2,
  output logic [47:0] addr48,
  output logic [31:0] tx_data,
  output logic [13:1] ctrl_q,
  output logic        go_active,
  output logic        go_start,
  output logic        done_flag,
  output logic        err_flag
);
  logic [31:0] addr_lo, resp;
  logic [15:0] addr_hi;
  logic        go_req;

  assign addr48 = {addr_hi, addr_lo};
  assign go_req = wr_en && (wr_addr == RA_CTRL) && wr_data[CB_GO] && !go_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      opc1 <= '0; opc2 <= '0; addr_lo <= '0; addr_hi <= '0;
      tx_data <= '0; ctrl_q <= '0; resp <= '0;
      go_active <= 1'b0; go_start <= 1'b0;
      done_flag <= 1'b0; err_flag <= 1'b0;
      rd_data <= '0;
    end else begin
      go_start <= go_req;
      if (wr_en) begin
        case (wr_addr)
          RA_OPC1:   opc1    <= wr_data[7:0];
          RA_OPC2:   opc2    <= wr_data[7:0];
          RA_ADDRLO: addr_lo <= wr_data;
          RA_ADDRHI: addr_hi <= wr_data[15:0];
          RA_TXD:    tx_data <= wr_data;
          RA_CTRL: begin
            if (go_active) err_flag <= 1'b1;
            else begin
              ctrl_q    <= wr_data[13:1];
              go_active <= wr_data[CB_GO];
            end
          end
          RA_STAT: begin
            if (wr_data[0]) done_flag <= 1'b0;
            if (wr_data[1]) err_flag  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (seq_finish) begin
        go_active <= 1'b0;
        done_flag <= 1'b1;
      end
      if (go_req) resp <= '0;
      else if (resp_wr) resp[{resp_lane, 3'b000} +: 8] <= resp_byte;
      case (rd_addr)
        RA_OPC1:   rd_data <= {24'b0, opc1};
        RA_OPC2:   rd_data <= {24'b0, opc2};
        RA_ADDRLO: rd_data <= addr_lo;
        RA_ADDRHI: rd_data <= {16'b0, addr_hi};
        RA_CTRL:   rd_data <= {18'b0, ctrl_q, go_active};
        RA_STAT:   rd_data <= {28'b0, rb, go_active, err_flag, done_flag};
        RA_RESP:   rd_data <= resp;
        default:   rd_data <= tx_data;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int T_WB = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go_start,
  input  logic [13:1] ctrl_q,
  input  logic [7:0]  opc1,
  input  logic [7:0]  opc2,
  input  logic [47:0] addr48,
  input  logic [31:0] tx_data,
  input  logic [7:0]  io_in,
  input  logic        rb,
  input  logic        strb_busy,
  input  logic        strb_sample,
  input  logic        strb_done,
  output logic        strb_start,
  output seq_state_t  state,
  output logic [7:0]  io_out,
  output logic        resp_wr,
  output logic [1:0]  resp_lane,
  output logic [7:0]  resp_byte,
  output logic        finish
);
  localparam int WBW = $clog2(T_WB + 1);
  localparam logic [WBW-1:0] WB_LAST = WBW'(T_WB - 1);

  logic [2:0]     idx;
  logic [WBW-1:0] wb_cnt;
  logic [2:0]     n_addr_m1;
  seq_state_t     after_cmd2, after_addr, after_cmd1, first_ph, nxt;
  logic           byte_state, last_byte;

  always_comb begin
    case (ctrl_q[9:8])
      2'd0:    n_addr_m1 = 3'd0;
      2'd1:    n_addr_m1 = 3'd2;
      2'd2:    n_addr_m1 = 3'd3;
      default: n_addr_m1 = 3'd4;
    endcase
    after_cmd2 = ctrl_q[CB_PIO]  ? S_DATA : S_WB;
    after_addr = ctrl_q[CB_CMD2] ? S_CMD2 : after_cmd2;
    after_cmd1 = ctrl_q[CB_ALE]  ? S_ADDR : after_addr;
    first_ph   = ctrl_q[CB_CLE]  ? S_CMD1 : after_cmd1;
    case (state)
      S_CMD1:  nxt = after_cmd1;
      S_ADDR:  nxt = after_addr;
      S_CMD2:  nxt = after_cmd2;
      default: nxt = S_WB;
    endcase
  end

  assign byte_state = (state == S_CMD1) || (state == S_ADDR) ||
                      (state == S_CMD2) || (state == S_DATA);
  assign last_byte  = (state == S_ADDR) ? (idx == n_addr_m1) :
                      (state == S_DATA) ? (idx == {1'b0, ctrl_q[13:12]}) : 1'b1;
  assign strb_start = byte_state && !strb_busy;
  assign finish     = (state == S_RB) && rb;
  assign resp_wr    = (state == S_DATA) && !ctrl_q[CB_TX] && strb_sample;
  assign resp_lane  = idx[1:0];
  assign resp_byte  = io_in;

  always_comb begin
    case (state)
      S_CMD1:  io_out = opc1;
      S_CMD2:  io_out = opc2;
      S_ADDR:  io_out = addr48[{idx, 3'b000} +: 8];
      S_DATA:  io_out = tx_data[{idx[1:0], 3'b000} +: 8];
      default: io_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      idx    <= '0;
      wb_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (go_start) begin state <= first_ph; idx <= '0; wb_cnt <= '0; end
        S_WB: begin
          if (wb_cnt == WB_LAST) state <= S_RB;
          else wb_cnt <= wb_cnt + 1'b1;
        end
        S_RB: if (rb) state <= S_IDLE;
        default: if (strb_done) begin
          if (last_byte) begin state <= nxt; idx <= '0; end
          else idx <= idx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int T_LOW  = 2,
  parameter int T_HIGH = 2,
  parameter int T_WB   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb
);
  logic [7:0]  opc1, opc2, resp_byte;
  logic [47:0] addr48;
  logic [31:0] tx_data;
  logic [13:1] ctrl_q;
  logic        go_active, go_start, done_flag, err_flag, finish;
  logic        resp_wr, strb_start, strb_busy, strb_low, strb_sample, strb_done;
  logic [1:0]  resp_lane;
  seq_state_t  state;
  logic        rx_phase;

  nand_seq_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .seq_finish(finish),
    .resp_wr(resp_wr), .resp_lane(resp_lane), .resp_byte(resp_byte), .rb(nand_rb),
    .opc1(opc1), .opc2(opc2), .addr48(addr48), .tx_data(tx_data), .ctrl_q(ctrl_q),
    .go_active(go_active), .go_start(go_start), .done_flag(done_flag), .err_flag(err_flag)
  );

  nand_strobe_gen #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_strb (
    .clk(clk), .rst(rst), .start(strb_start), .busy(strb_busy),
    .low(strb_low), .sample(strb_sample), .done(strb_done)
  );

  nand_seq_fsm #(.T_WB(T_WB)) u_fsm (
    .clk(clk), .rst(rst), .go_start(go_start), .ctrl_q(ctrl_q),
    .opc1(opc1), .opc2(opc2), .addr48(addr48), .tx_data(tx_data),
    .io_in(nand_io_in), .rb(nand_rb), .strb_busy(strb_busy),
    .strb_sample(strb_sample), .strb_done(strb_done), .strb_start(strb_start),
    .state(state), .io_out(nand_io_out), .resp_wr(resp_wr),
    .resp_lane(resp_lane), .resp_byte(resp_byte), .finish(finish)
  );

  assign rx_phase    = (state == S_DATA) && !ctrl_q[CB_TX];
  assign nand_ce_n   = !((state != S_IDLE) && ctrl_q[CB_CE]);
  assign nand_cle    = (state == S_CMD1) || (state == S_CMD2);
  assign nand_ale    = (state == S_ADDR);
  assign nand_we_n   = !(strb_low && !rx_phase);
  assign nand_re_n   = !(strb_low && rx_phase);
  assign nand_io_oe  = nand_cle || nand_ale || ((state == S_DATA) && ctrl_q[CB_TX]);
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int T_LOW = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_io_oe,
  input logic       nand_rb,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       go_active,
  input logic       done_flag,
  input logic       err_flag
);
  logic [15:0] we_low_cnt;
  always_ff @(posedge clk) begin
    if (rst || nand_we_n) we_low_cnt <= '0;
    else we_low_cnt <= we_low_cnt + 1'b1;
  end

  p_cle_ale_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));
  p_rx_no_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_io_oe);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));
  p_we_width_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> (we_low_cnt == 16'(T_LOW)));
  p_go_held_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (go_active && !nand_rb) |=> go_active);
  p_done_after_ready_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(nand_rb));
  p_busy_write_err_r9: assert property (@(posedge clk) disable iff (rst)
    (go_active && wr_en && wr_addr == 3'd4) |=> err_flag);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.T_LOW(T_LOW)) u_chk (
  .clk(clk), .rst(rst), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_oe(nand_io_oe),
  .nand_rb(nand_rb), .wr_en(wr_en), .wr_addr(wr_addr),
  .go_active(go_active), .done_flag(done_flag), .err_flag(err_flag)
);

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_LOW  = 2;
  localparam int T_HIGH = 2;
  localparam int T_WB   = 4;
  localparam int BUSY_CYC = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in;
  logic        nand_rb = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_q[$];
  logic [7:0]  rx_mem [4];
  int          rx_ptr = 0;
  int          busy_cnt = 0;
  logic        prev_we = 1'b1, prev_re = 1'b1;
  int          we_lo = 0, re_lo = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_seq #(.T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_WB(T_WB)) u_nand_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rb(nand_rb)
  );

  assign nand_io_in = rx_mem[rx_ptr % 4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop at each WE rising edge, strobe widths, device model
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_we == 1'b0 && nand_we_n == 1'b1) begin
        chk("R11 we low width", 32'(we_lo), 32'(T_LOW));
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2/R9: unexpected write cycle actual 0x%0h expected none",
                   {nand_ce_n, nand_cle, nand_ale, nand_io_out});
        end else begin
          chk("R2/R4/R8/R12 bus cycle", 32'({nand_ce_n, nand_cle, nand_ale, nand_io_out}),
              32'(exp_q.pop_front()));
        end
        if (nand_cle && (nand_io_out == 8'hD0 || nand_io_out == 8'hFF)) begin
          nand_rb  = 1'b0;
          busy_cnt = BUSY_CYC;
        end
      end else if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0) nand_rb = 1'b1;
      end
      if (prev_re == 1'b0 && nand_re_n == 1'b1) begin
        chk("R11 re low width", 32'(re_lo), 32'(T_LOW));
        rx_ptr++;
      end
      we_lo = nand_we_n ? 0 : we_lo + 1;
      re_lo = nand_re_n ? 0 : re_lo + 1;
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic push(input logic ce_n, input logic cle, input logic ale, input logic [7:0] b);
    exp_q.push_back({ce_n, cle, ale, b});
  endtask

  task automatic run_cmd(input logic [31:0] ctrl, input string req);
    logic [31:0] s;
    wr(3'd5, 32'h3);
    wr(3'd4, ctrl);
    s = 32'h4;
    for (int i = 0; i < 500 && s[2]; i++) rd(3'd5, s);
    chk({req, " R7 run clears, done set"}, s & 32'h7, 32'h1);
    chk({req, " R2 all expected cycles seen"}, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    rx_mem[0] = 8'hEC; rx_mem[1] = 8'hDA; rx_mem[2] = 8'h10; rx_mem[3] = 8'h95;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pins idle", {28'b0, nand_ce_n, nand_we_n, nand_re_n, nand_io_oe}, 32'hE);
    rd(3'd5, v);
    chk("R1 status", v & 32'h7, 32'h0);

    // R2 reset command: single CLE byte, device goes busy
    wr(3'd0, 32'hFF);
    push(1'b0, 1'b1, 1'b0, 8'hFF);
    run_cmd(32'h43, "reset");

    // R5 id read: CLE 90, one address byte, four bytes received
    wr(3'd0, 32'h90); wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    push(1'b0, 1'b1, 1'b0, 8'h90);
    push(1'b0, 1'b0, 1'b1, 8'h00);
    rx_ptr = 0;
    run_cmd(32'h3057, "id");
    rd(3'd6, v);
    chk("R5 four bytes little-endian", v, 32'h9510DAEC);

    // R5 status read: one byte, upper lanes zero
    wr(3'd0, 32'h70);
    push(1'b0, 1'b1, 1'b0, 8'h70);
    rx_ptr = 2;
    run_cmd(32'h0053, "status");
    rd(3'd6, v);
    chk("R5 single byte, rest zero", v, 32'h00000010);

    // R3/R4/R6 erase: 3 address bytes, confirm, busy wait
    wr(3'd0, 32'h60); wr(3'd1, 32'hD0); wr(3'd2, 32'h00012345); wr(3'd3, 32'h0);
    push(1'b0, 1'b1, 1'b0, 8'h60);
    push(1'b0, 1'b0, 1'b1, 8'h45);
    push(1'b0, 1'b0, 1'b1, 8'h23);
    push(1'b0, 1'b0, 1'b1, 8'h01);
    push(1'b0, 1'b1, 1'b0, 8'hD0);
    wr(3'd5, 32'h3);
    wr(3'd4, 32'h014F);
    for (int i = 0; i < 400 && nand_rb; i++) @(negedge clk);
    rd(3'd5, v);
    chk("R6 run held, done clear while busy", v & 32'hF, 32'h4);
    v = 32'h4;
    for (int i = 0; i < 500 && v[2]; i++) rd(3'd5, v);
    chk("R7 erase done", v & 32'h7, 32'h1);
    chk("R3 erase cycles seen", 32'(exp_q.size()), 32'd0);

    // R3/R4 page read setup: 5 address bytes then second opcode
    wr(3'd0, 32'h00); wr(3'd1, 32'h30); wr(3'd2, 32'h56780812); wr(3'd3, 32'h0009);
    push(1'b0, 1'b1, 1'b0, 8'h00);
    push(1'b0, 1'b0, 1'b1, 8'h12);
    push(1'b0, 1'b0, 1'b1, 8'h08);
    push(1'b0, 1'b0, 1'b1, 8'h78);
    push(1'b0, 1'b0, 1'b1, 8'h56);
    push(1'b0, 1'b0, 1'b1, 8'h09);
    push(1'b0, 1'b1, 1'b0, 8'h30);
    run_cmd(32'h034F, "R4 page read");

    // R3 four-byte address code
    wr(3'd0, 32'h80); wr(3'd2, 32'hAABBCCDD);
    push(1'b0, 1'b1, 1'b0, 8'h80);
    push(1'b0, 1'b0, 1'b1, 8'hDD);
    push(1'b0, 1'b0, 1'b1, 8'hCC);
    push(1'b0, 1'b0, 1'b1, 8'hBB);
    push(1'b0, 1'b0, 1'b1, 8'hAA);
    run_cmd(32'h0247, "R3 four bytes");

    // R8 transmit two bytes, no CLE/ALE
    wr(3'd7, 32'hA1B2C3D4);
    push(1'b0, 1'b0, 1'b0, 8'hD4);
    push(1'b0, 1'b0, 1'b0, 8'hC3);
    run_cmd(32'h1071, "R8 tx");

    // R12 chip enable bit clear
    wr(3'd0, 32'hFF);
    push(1'b1, 1'b1, 1'b0, 8'hFF);
    run_cmd(32'h0003, "R12 ce off");

    // R9 control write while busy is dropped and flagged
    wr(3'd5, 32'h3);
    push(1'b0, 1'b1, 1'b0, 8'hFF);
    wr(3'd4, 32'h43);
    for (int i = 0; i < 400 && nand_rb; i++) @(negedge clk);
    wr(3'd4, 32'h034F);
    v = 32'h4;
    for (int i = 0; i < 500 && v[2]; i++) rd(3'd5, v);
    chk("R9 error and done set", v & 32'h7, 32'h3);
    chk("R9 no extra cycles", 32'(exp_q.size()), 32'd0);
    rd(3'd4, v);
    chk("R9 control word unchanged", v, 32'h42);

    // R10 write-one-to-clear
    wr(3'd5, 32'h0);
    rd(3'd5, v);
    chk("R10 zero write keeps flags", v & 32'h3, 32'h3);
    wr(3'd5, 32'h2);
    rd(3'd5, v);
    chk("R10 clear error only", v & 32'h3, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, v);
    chk("R10 clear done", v & 32'h3, 32'h0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule